// File: doc/BRIEF.md
# Interrupt Response Sequencer

This block sits next to a small 8-bit processor core and carries out the response to an interrupt once the core is ready to take one. It holds a two-bit response mode and an 8-bit page register, both loaded by write strobes from the core. When a non-maskable request is present it produces the fixed restart target 0x0066 at once. When a maskable request is accepted, it first runs an acknowledge cycle toward the interrupting device. That cycle is lengthened by fixed wait states so that an external priority chain has time to settle. The sequencer captures the byte the device drives during the cycle.

What happens next depends on the mode that was in force at acceptance. In the opcode mode, the captured byte goes back to the core to be executed as an instruction. In the restart mode, the target is the fixed address 0x0038. In the table mode, the sequencer builds a 16-bit pointer from the page register and the device byte, reads two bytes from a memory table through a synchronous read port, and forms the service address from them. Every response ends with a one-cycle done strobe. The target, the execute flag and the opcode are held on the outputs at that point.

Top module: `irq_resp_seq`

## Requirements
- R1: After a synchronous reset, `busy_o`, `done_o`, `ack_o` and `mem_rd_o` are low, the response mode is 0 (opcode mode) and the page register is 0x00.
- R2: An accepted maskable request raises `ack_o` in the cycle after acceptance and keeps it high for ACK_BASE+WAIT_STATES cycles (2 base + 2 wait = 4 by default). `ack_data_i` is sampled in the last of those cycles.
- R3: Mode codes 0 and 3 (opcode mode) end with `done_o` 5 cycles after the acceptance edge. At that point `exec_o`=1, `opcode_o` equals the captured device byte and `target_o`=0x0000.
- R4: Mode code 1 (restart mode) ends with `done_o` 5 cycles after acceptance, with `target_o`=0x0038 and `exec_o`=0.
- R5: A non-maskable request, in any mode, runs no acknowledge cycle. It ends with `done_o` 1 cycle after acceptance, with `target_o`=0x0066 and `exec_o`=0.
- R6: Mode code 2 (table mode) reads address {page, byte[7:1], 0} and then that address with bit 0 set. Each read occupies one `mem_rd_o` cycle, and data returns one cycle after the read. The response ends with `done_o` 8 cycles after acceptance and `target_o` = {second byte, first byte}.
- R7: A pulse on `page_wr_i` loads `page_wdata_i` into the page register, which reset clears to 0x00.
- R8: When both requests are present in the same idle cycle, the non-maskable request wins. A maskable request is accepted only while `int_en_i` is high.
- R9: `busy_o` rises in the cycle after acceptance, stays high through the single cycle in which `done_o` is high, and then falls. Requests that arrive while `busy_o` is high are ignored.
- R10: A mode write during a response does not change that response. It applies from the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req_i | input | 1 | Non-maskable request |
| int_req_i | input | 1 | Maskable request |
| int_en_i | input | 1 | Maskable acceptance enable |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 2 | New mode code |
| page_wr_i | input | 1 | Page register write strobe |
| page_wdata_i | input | 8 | New page value |
| ack_o | output | 1 | Acknowledge cycle toward the device |
| ack_data_i | input | 8 | Byte driven by the device during acknowledge |
| mem_rd_o | output | 1 | Table read request |
| mem_addr_o | output | 16 | Table read address |
| mem_rdata_i | input | 8 | Table read data, one cycle after the request |
| busy_o | output | 1 | Response in progress |
| done_o | output | 1 | One-cycle completion strobe |
| exec_o | output | 1 | With done: opcode_o is to be executed |
| opcode_o | output | 8 | Captured device byte |
| target_o | output | 16 | Jump target |

## Verification
The assertions rely on the memory port returning data exactly one cycle after `mem_rd_o` and on reset being held for at least one clock. The bench's memory model is registered on `mem_rd_o`, so it always keeps that latency. The bench drives `ack_data_i` before a maskable request and holds it steady through the whole response, so the last acknowledge cycle always samples a defined byte. Requests are pulsed for a single accepting edge, except in the cases where the test is meant to show that held or repeated requests are ignored during a response.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;
  localparam int MODE_W = 2;

  localparam logic [MODE_W-1:0] MD_OPCODE = 2'd0;
  localparam logic [MODE_W-1:0] MD_RESTART = 2'd1;
  localparam logic [MODE_W-1:0] MD_TABLE = 2'd2;

  localparam logic [15:0] VEC_NMI = 16'h0066;
  localparam logic [15:0] VEC_RESTART = 16'h0038;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_TBL,
    ST_FIN,
    ST_END
  } seq_st_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_resp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              page_wr,
  input  logic [DW-1:0]     page_wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic [DW-1:0]     page_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_OPCODE;
      page_q <= '0;
    end else begin
      if (mode_wr) mode_q <= mode_wdata;
      if (page_wr) page_q <= page_wdata;
    end
  end

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!page_wr && !$past(rst)) |=> $stable(page_q)) else $error("page changed without write"); // R7
endmodule

// File: rtl/irq_ack_timer.sv
module irq_ack_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ack_o,
  output logic last_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign last_o = ack_o && (cnt_q == CW'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      ack_o <= 1'b1;
      cnt_q <= '0;
    end else if (ack_o) begin
      if (last_o) begin
        ack_o <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  AST_ACK_SPAN: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> $past(cnt_q) == CW'(CYCLES - 1)) else $error("ack length wrong"); // R2
  AST_ACK_CONT: assert property (@(posedge clk) disable iff (rst)
    (ack_o && !last_o) |=> ack_o) else $error("ack dropped early"); // R2
endmodule

// File: rtl/irq_tbl_reader.sv
module irq_tbl_reader #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2*DW-1:0] ptr,
  output logic            mem_rd_o,
  output logic [2*DW-1:0] mem_addr_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [2*DW-1:0] word_o,
  output logic            valid_o
);
  localparam int AW = 2 * DW;

  logic [1:0]    ph_q;
  logic [DW-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= 2'd0;
      mem_rd_o   <= 1'b0;
      mem_addr_o <= '0;
      lo_q       <= '0;
      word_o     <= '0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (ph_q)
        2'd0: if (start) begin
          mem_rd_o   <= 1'b1;
          mem_addr_o <= ptr;
          ph_q       <= 2'd1;
        end
        2'd1: begin
          mem_addr_o <= mem_addr_o | AW'(1);
          ph_q       <= 2'd2;
        end
        2'd2: begin
          mem_rd_o <= 1'b0;
          lo_q     <= mem_rdata_i;
          ph_q     <= 2'd3;
        end
        default: begin
          word_o  <= {mem_rdata_i, lo_q};
          valid_o <= 1'b1;
          ph_q    <= 2'd0;
        end
      endcase
    end
  end

  AST_TBL_EVEN: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_o) |-> !mem_addr_o[0]) else $error("first table read odd"); // R6
  AST_TBL_NEXT: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o && $past(mem_rd_o)) |-> mem_addr_o == ($past(mem_addr_o) | AW'(1))) else $error("second read address"); // R6
  AST_TBL_TWO: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o && $past(mem_rd_o)) |=> !mem_rd_o) else $error("too many reads"); // R6
endmodule

// File: rtl/irq_resp_seq.sv
module irq_resp_seq
  import irq_resp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int ACK_BASE    = 2,
  parameter int WAIT_STATES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_req_i,
  input  logic              int_req_i,
  input  logic              int_en_i,
  input  logic              mode_wr_i,
  input  logic [1:0]        mode_wdata_i,
  input  logic              page_wr_i,
  input  logic [DW-1:0]     page_wdata_i,
  output logic              ack_o,
  input  logic [DW-1:0]     ack_data_i,
  output logic              mem_rd_o,
  output logic [2*DW-1:0]   mem_addr_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              exec_o,
  output logic [DW-1:0]     opcode_o,
  output logic [2*DW-1:0]   target_o
);
  localparam int AW       = 2 * DW;
  localparam int ACK_CYCS = ACK_BASE + WAIT_STATES;

  seq_st_t           state_q;
  logic [MODE_W-1:0] mode_q, mode_cur_q;
  logic [DW-1:0]     page_q;
  logic              nmi_cur_q;
  logic              ack_last, tbl_valid;
  logic [AW-1:0]     tbl_word, tbl_ptr;
  logic              take_nmi, take_int, tbl_start;

  assign take_nmi  = (state_q == ST_IDLE) && nmi_req_i;
  assign take_int  = (state_q == ST_IDLE) && !nmi_req_i && int_req_i && int_en_i;
  assign tbl_start = ack_last && (mode_cur_q == MD_TABLE);
  assign tbl_ptr   = {page_q, ack_data_i[DW-1:1], 1'b0};

  irq_cfg_regs #(.DW(DW)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .mode_wr    (mode_wr_i),
    .mode_wdata (mode_wdata_i),
    .page_wr    (page_wr_i),
    .page_wdata (page_wdata_i),
    .mode_q     (mode_q),
    .page_q     (page_q)
  );

  irq_ack_timer #(.CYCLES(ACK_CYCS)) u_ack (
    .clk    (clk),
    .rst    (rst),
    .start  (take_int),
    .ack_o  (ack_o),
    .last_o (ack_last)
  );

  irq_tbl_reader #(.DW(DW)) u_tbl (
    .clk         (clk),
    .rst         (rst),
    .start       (tbl_start),
    .ptr         (tbl_ptr),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .word_o      (tbl_word),
    .valid_o     (tbl_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mode_cur_q <= MD_OPCODE;
      nmi_cur_q  <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      exec_o     <= 1'b0;
      opcode_o   <= '0;
      target_o   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (take_nmi) begin
            nmi_cur_q <= 1'b1;
            busy_o    <= 1'b1;
            state_q   <= ST_FIN;
          end else if (take_int) begin
            nmi_cur_q  <= 1'b0;
            busy_o     <= 1'b1;
            mode_cur_q <= mode_q;
            state_q    <= ST_ACK;
          end
        end
        ST_ACK: if (ack_last) begin
          opcode_o <= ack_data_i;
          state_q  <= (mode_cur_q == MD_TABLE) ? ST_TBL : ST_FIN;
        end
        ST_TBL: if (tbl_valid) begin
          target_o <= tbl_word;
          exec_o   <= 1'b0;
          done_o   <= 1'b1;
          state_q  <= ST_END;
        end
        ST_FIN: begin
          done_o  <= 1'b1;
          state_q <= ST_END;
          if (nmi_cur_q) begin
            target_o <= AW'(VEC_NMI);
            exec_o   <= 1'b0;
          end else if (mode_cur_q == MD_RESTART) begin
            target_o <= AW'(VEC_RESTART);
            exec_o   <= 1'b0;
          end else begin
            target_o <= '0;
            exec_o   <= 1'b1;
          end
        end
        default: begin
          done_o  <= 1'b0;
          exec_o  <= 1'b0;
          busy_o  <= 1'b0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R9
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_o) else $error("done without busy"); // R9
  AST_NMI_TARGET: assert property (@(posedge clk) disable iff (rst)
    (done_o && nmi_cur_q) |-> target_o == AW'(VEC_NMI)) else $error("nmi target"); // R5
  AST_NMI_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (busy_o && nmi_cur_q) |-> !ack_o) else $error("ack during nmi"); // R5
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(mode_cur_q)) else $error("mode moved mid-response"); // R10
  AST_ACK_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> busy_o) else $error("ack outside response"); // R2
endmodule

// File: tb/sim_irq_resp_seq.sv
`timescale 1ns/1ps
module sim_irq_resp_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_req_i = 1'b0, int_req_i = 1'b0, int_en_i = 1'b1;
  logic        mode_wr_i = 1'b0, page_wr_i = 1'b0;
  logic [1:0]  mode_wdata_i = 2'd0;
  logic [7:0]  page_wdata_i = 8'd0, ack_data_i = 8'd0, mem_rdata_i = 8'd0;
  logic        ack_o, mem_rd_o, busy_o, done_o, exec_o;
  logic [15:0] mem_addr_o, target_o;
  logic [7:0]  opcode_o;

  int n_chk = 0, n_fail = 0;
  bit ended = 0;
  int lat, acks, n_rd;
  logic [15:0] rd_a0, rd_a1, got_t;
  logic        got_x;
  logic [7:0]  got_op;
  logic [7:0]  bset [0:6];
  logic [7:0]  pset [0:2];

  always #2 clk = ~clk;

  irq_resp_seq u0 (
    .clk(clk), .rst(rst), .nmi_req_i(nmi_req_i), .int_req_i(int_req_i), .int_en_i(int_en_i),
    .mode_wr_i(mode_wr_i), .mode_wdata_i(mode_wdata_i), .page_wr_i(page_wr_i),
    .page_wdata_i(page_wdata_i), .ack_o(ack_o), .ack_data_i(ack_data_i), .mem_rd_o(mem_rd_o),
    .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
    .exec_o(exec_o), .opcode_o(opcode_o), .target_o(target_o)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  always_ff @(posedge clk) if (mem_rd_o) mem_rdata_i <= memf(mem_addr_o);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode_wr_i = 1'b1; mode_wdata_i = m;
    @(negedge clk); mode_wr_i = 1'b0;
  endtask

  task automatic set_page(input logic [7:0] p);
    @(negedge clk); page_wr_i = 1'b1; page_wdata_i = p;
    @(negedge clk); page_wr_i = 1'b0;
  endtask

  // One response: pulse requests for the accepting edge, then watch until done.
  // inj: hold both requests while busy; chg: write mode 2 during the response.
  task automatic run_resp(input bit nmi, input bit intr, input bit inj, input bit chg);
    @(negedge clk); nmi_req_i = nmi; int_req_i = intr;
    @(posedge clk);
    @(negedge clk); nmi_req_i = 1'b0; int_req_i = 1'b0;
    lat = 0; acks = 0; n_rd = 0;
    if (ack_o) acks++;
    if (mem_rd_o) begin rd_a0 = mem_addr_o; n_rd++; end
    if (chg) begin mode_wr_i = 1'b1; mode_wdata_i = 2'd2; end
    while (1) begin
      @(posedge clk); lat++;
      @(negedge clk);
      mode_wr_i = 1'b0;
      if (inj) begin nmi_req_i = 1'b1; int_req_i = 1'b1; end
      if (ack_o) acks++;
      if (mem_rd_o) begin
        if (n_rd == 0) rd_a0 = mem_addr_o; else rd_a1 = mem_addr_o;
        n_rd++;
      end
      if (done_o) begin
        got_t = target_o; got_x = exec_o; got_op = opcode_o;
        chk(busy_o, "R9 busy with done", 32'(busy_o), 1);
        nmi_req_i = 1'b0; int_req_i = 1'b0;
        break;
      end
      if (lat > 40) begin
        chk(0, "watchdog: no done", lat, 8);
        break;
      end
    end
    @(posedge clk); @(negedge clk);
    chk(!busy_o && !done_o, "R9 busy falls after done", {busy_o, done_o}, 0);
  endtask

  initial begin
    #(200000 * 4);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    bset[0] = 8'h00; bset[1] = 8'h01; bset[2] = 8'h7F; bset[3] = 8'h80;
    bset[4] = 8'hFE; bset[5] = 8'hFF; bset[6] = 8'h55;
    pset[0] = 8'h00; pset[1] = 8'hA5; pset[2] = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk({busy_o, done_o, ack_o, mem_rd_o} == 4'b0, "R1 reset outputs", {busy_o, done_o, ack_o, mem_rd_o}, 0);

    // R1/R3: mode after reset is opcode mode
    ack_data_i = 8'hC7;
    run_resp(0, 1, 0, 0);
    chk(got_x == 1'b1 && got_op == 8'hC7, "R1 default mode 0", {got_x, got_op}, {1'b1, 8'hC7});
    chk(lat == 5, "R3 latency", lat, 5);

    // R7: page reset value seen through table pointer
    set_mode(2'd2);
    ack_data_i = 8'h13;
    run_resp(0, 1, 0, 0);
    chk(rd_a0 == 16'h0012, "R7 page cleared by reset", rd_a0, 16'h0012);

    // Sweep modes x pages x device bytes
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1:0]);
      for (int p = 0; p < 3; p++) begin
        set_page(pset[p]);
        for (int b = 0; b < 7; b++) begin
          logic [15:0] ptr;
          ack_data_i = bset[b];
          ptr = {pset[p], bset[b] & 8'hFE};
          run_resp(0, 1, 0, 0);
          chk(acks == 4, "R2 ack cycles", acks, 4);
          if (m == 1) begin
            chk(lat == 5, "R4 latency", lat, 5);
            chk(got_t == 16'h0038 && !got_x, "R4 restart target", got_t, 16'h0038);
          end else if (m == 2) begin
            chk(lat == 8, "R6 latency", lat, 8);
            chk(n_rd == 2, "R6 read count", n_rd, 2);
            chk(rd_a0 == ptr, "R6 first addr", rd_a0, ptr);
            chk(rd_a1 == (ptr | 16'h1), "R6 second addr", rd_a1, ptr | 16'h1);
            chk(got_t == {memf(ptr | 16'h1), memf(ptr)}, "R6 table target R7 page", got_t,
                {memf(ptr | 16'h1), memf(ptr)});
          end else begin
            chk(lat == 5, "R3 latency", lat, 5);
            chk(got_x && got_op == bset[b] && got_t == 16'h0, "R3 opcode pass", {got_x, got_op, got_t},
                {1'b1, bset[b], 16'h0});
          end
        end
      end
      // R5: non-maskable in every mode
      run_resp(1, 0, 0, 0);
      chk(lat == 1 && acks == 0, "R5 nmi timing", {lat[15:0], acks[15:0]}, 32'h00010000);
      chk(got_t == 16'h0066 && !got_x, "R5 nmi target", got_t, 16'h0066);
    end

    // R8: enable low blocks maskable requests
    int_en_i = 1'b0;
    @(negedge clk); int_req_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!busy_o && !ack_o, "R8 disabled int ignored", {busy_o, ack_o}, 0);
    end
    int_req_i = 1'b0; int_en_i = 1'b1;

    // R8: priority when both arrive together
    set_mode(2'd1);
    run_resp(1, 1, 0, 0);
    chk(got_t == 16'h0066 && acks == 0, "R8 nmi wins", got_t, 16'h0066);

    // R9: requests during a table response are ignored
    set_mode(2'd2); set_page(8'h3C); ack_data_i = 8'h41;
    run_resp(0, 1, 1, 0);
    chk(got_t == {memf(16'h3C41), memf(16'h3C40)}, "R9 response unchanged", got_t,
        {memf(16'h3C41), memf(16'h3C40)});
    @(negedge clk);
    chk(!busy_o && !ack_o, "R9 held requests ignored", {busy_o, ack_o}, 0);

    // R10: mode write mid-response applies from next acceptance
    set_mode(2'd1);
    run_resp(0, 1, 0, 1);
    chk(got_t == 16'h0038 && lat == 5, "R10 latched mode", got_t, 16'h0038);
    run_resp(0, 1, 0, 0);
    chk(lat == 8, "R10 new mode applied", lat, 8);

    finish_run();
  end
endmodule